// File: doc/BRIEF.md
# Multi-cycle register-transfer processor core

This block is a small processor core that runs each instruction as a chain of single transfers between registers. A step counter walks through the chain. In each step one source drives an internal transfer bus and one destination register captures it. The registers on that bus are:

- an address latch for memory;
- a data latch for memory;
- the instruction register;
- the program counter;
- a 32-entry register file;
- three scratch registers (first operand, second operand, result) around an arithmetic/logic unit.

Instructions are 32 bits wide and memory is byte addressed, so consecutive instructions sit four addresses apart. The core fetches an instruction, then executes it, then fetches the next one, and never overlaps the two phases. Execution covers four register-to-register operations, a stop instruction, and a no-op treatment of every other operation code.

The memory side is a synchronous read port. The core presents an address and pulses a read strobe, and the memory returns the word on the following cycle. A debug port can read any register at any time. It can also write a register, which lets a host seed operands while the core is held in reset and inspect results after the core stops.

Top module: `mc_core`

## Requirements
- R1: Fetch takes five steps in this fixed order: the address latch takes the program counter; the read strobe is high for one cycle with the address latch on `mem_addr`; the data latch takes `mem_rdata` one cycle after the strobe; the instruction register takes the data latch; the program counter adds 4. After a reset is released, the first strobe comes in the second cycle.
- R2: Successive instruction fetches read addresses 0, 4, 8, ... in order.
- R3: A register-register operation executes in four steps after fetch: first operand from Rs1, second operand from Rs2, result from the ALU, then Rd from the result. Read strobes of successive such instructions are therefore 9 cycles apart.
- R4: The instruction fields are opcode in bits 31:26, Rd in 25:21, Rs1 in 20:16 and Rs2 in 15:11. The opcodes are 1 add, 2 subtract, 3 bitwise AND and 4 bitwise OR, all on 32 bits modulo 2^32.
- R5: Register 0 always reads as zero, both as a source operand and on the debug port. Writes to it, from the core or the debug port, are discarded.
- R6: Opcodes 5 to 63 change no register. Fetch resumes after one execute step, so the next read strobe comes 6 cycles after the current one.
- R7: Opcode 0 stops the core. `halted` goes high 5 cycles after that instruction's read strobe and stays high. No further read strobes appear while halted.
- R8: Reset (synchronous, active high) clears the program counter, the address latch, the instruction register and the step counter. During reset `halted` and `mem_rd` are low, and after a reset the core fetches from address 0 again.
- R9: `dbg_rdata` shows register `dbg_idx` combinationally. When `dbg_we` is high, `dbg_wdata` is written to register `dbg_idx` at the clock edge, unless the core writes a register on that edge, in which case the core's write wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | ADDR_W | Byte address driven from the address latch |
| mem_rd | output | 1 | Read strobe, one cycle per fetch |
| mem_rdata | input | DATA_W | Word returned by memory one cycle after the strobe |
| dbg_idx | input | log2(NREG) | Register selected by the debug port |
| dbg_we | input | 1 | Debug write enable |
| dbg_wdata | input | DATA_W | Debug write data |
| dbg_rdata | output | DATA_W | Contents of the selected register |
| halted | output | 1 | High once a stop instruction has executed |

## Verification
A program of 36 instructions plus a stop is built arithmetically. It cycles through all four ALU operations over a spread of register triples. Seeded operand values let add, subtract, AND and OR give distinct results, so a swapped decode is visible. The program also includes:

- a destination of register 0, which separates a discarded write from a stored one;
- a source of register 0, which shows whether the zero read holds on the operand path;
- a register that is both source and destination, which catches operands read after write-back;
- two undefined opcodes, whose 6-cycle spacing and unchanged registers tell a no-op apart from an ALU step.

Fetch addresses and the spacing between strobes expose a wrong program counter increment or an added or missing step. A second reset after the stop confirms that the core restarts from address 0.

// File: rtl/mc_pkg.sv
package mc_pkg;

   localparam logic [5:0] OPC_STOP = 6'd0;
   localparam logic [5:0] OPC_ADD  = 6'd1;
   localparam logic [5:0] OPC_SUB  = 6'd2;
   localparam logic [5:0] OPC_AND  = 6'd3;
   localparam logic [5:0] OPC_OR   = 6'd4;

   // step counter encoding; fetch steps first, then execute steps
   typedef enum logic [3:0] {
      ST_F_MAR  = 4'd0,
      ST_F_READ = 4'd1,
      ST_F_MDR  = 4'd2,
      ST_F_IR   = 4'd3,
      ST_F_PC   = 4'd4,
      ST_X_A    = 4'd5,
      ST_X_B    = 4'd6,
      ST_X_C    = 4'd7,
      ST_X_WB   = 4'd8,
      ST_STOP   = 4'd9
   } step_e;

   typedef enum logic [2:0] {
      SRC_NONE, SRC_PC, SRC_PCINC, SRC_MEM, SRC_MDR, SRC_RF, SRC_ALU, SRC_C
   } src_e;

   typedef enum logic [3:0] {
      DST_NONE, DST_MAR, DST_MDR, DST_IR, DST_PC, DST_A, DST_B, DST_C, DST_RF
   } dst_e;

   typedef struct packed {
      src_e src;
      dst_e dst;
      logic rf_sel_b;
      logic mem_rd;
   } xfer_t;

   function automatic logic is_alu_op(input logic [5:0] opc);
      return (opc >= OPC_ADD) && (opc <= OPC_OR);
   endfunction

endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
   parameter int DATA_W = 32,
   parameter int NREG   = 32,
   localparam int RIDX_W = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [RIDX_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [RIDX_W-1:0] raddr_a,
   output logic [DATA_W-1:0] rdata_a,
   input  logic [RIDX_W-1:0] raddr_d,
   output logic [DATA_W-1:0] rdata_d
);

   logic [NREG*DATA_W-1:0] flat;

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      if (g == 0) begin : g_zero
         assign flat[0 +: DATA_W] = '0;
      end else begin : g_store
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk) begin
            if (we && (waddr == RIDX_W'(g))) q <= wdata;
         end
         assign flat[g*DATA_W +: DATA_W] = q;
      end
   end

   assign rdata_a = flat[raddr_a*DATA_W +: DATA_W];
   assign rdata_d = flat[raddr_d*DATA_W +: DATA_W];

endmodule

// File: rtl/mc_alu.sv
module mc_alu #(
   parameter int DATA_W = 32
) (
   input  logic [5:0]        opc,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);
   import mc_pkg::*;

   always_comb begin
      case (opc)
         OPC_ADD: y = a + b;
         OPC_SUB: y = a - b;
         OPC_AND: y = a & b;
         OPC_OR:  y = a | b;
         default: y = '0;
      endcase
   end

endmodule

// File: rtl/mc_sequencer.sv
module mc_sequencer (
   input  logic               clk,
   input  logic               rst,
   input  logic [5:0]         opc,
   output mc_pkg::step_e      step,
   output mc_pkg::xfer_t      xfer
);
   import mc_pkg::*;

   step_e step_q, step_d;

   always_comb begin
      step_d = step_q;
      xfer   = '{src: SRC_NONE, dst: DST_NONE, rf_sel_b: 1'b0, mem_rd: 1'b0};
      case (step_q)
         ST_F_MAR: begin
            xfer.src = SRC_PC;    xfer.dst = DST_MAR; step_d = ST_F_READ;
         end
         ST_F_READ: begin
            xfer.mem_rd = 1'b1;   step_d = ST_F_MDR;
         end
         ST_F_MDR: begin
            xfer.src = SRC_MEM;   xfer.dst = DST_MDR; step_d = ST_F_IR;
         end
         ST_F_IR: begin
            xfer.src = SRC_MDR;   xfer.dst = DST_IR;  step_d = ST_F_PC;
         end
         ST_F_PC: begin
            xfer.src = SRC_PCINC; xfer.dst = DST_PC;  step_d = ST_X_A;
         end
         ST_X_A: begin
            if (opc == OPC_STOP) begin
               step_d = ST_STOP;
            end else if (is_alu_op(opc)) begin
               xfer.src = SRC_RF; xfer.dst = DST_A; step_d = ST_X_B;
            end else begin
               step_d = ST_F_MAR;
            end
         end
         ST_X_B: begin
            xfer.src = SRC_RF; xfer.rf_sel_b = 1'b1; xfer.dst = DST_B;
            step_d = ST_X_C;
         end
         ST_X_C: begin
            xfer.src = SRC_ALU;   xfer.dst = DST_C;   step_d = ST_X_WB;
         end
         ST_X_WB: begin
            xfer.src = SRC_C;     xfer.dst = DST_RF;  step_d = ST_F_MAR;
         end
         ST_STOP: step_d = ST_STOP;
         default: step_d = ST_F_MAR;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) step_q <= ST_F_MAR;
      else     step_q <= step_d;
   end

   assign step = step_q;

endmodule

// File: rtl/mc_core.sv
module mc_core #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32,
   parameter int NREG   = 32,
   localparam int RIDX_W = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [RIDX_W-1:0] dbg_idx,
   input  logic              dbg_we,
   input  logic [DATA_W-1:0] dbg_wdata,
   output logic [DATA_W-1:0] dbg_rdata,
   output logic              halted
);
   import mc_pkg::*;

   localparam int ILEN = 32;

   if (DATA_W < ILEN) begin : g_bad_data_w
      $error("mc_core: DATA_W must hold a 32-bit instruction");
   end
   if ((ADDR_W < 3) || (ADDR_W > DATA_W)) begin : g_bad_addr_w
      $error("mc_core: ADDR_W must be in 3..DATA_W");
   end
   if ((NREG < 2) || (NREG > 32) || ((NREG & (NREG - 1)) != 0)) begin : g_bad_nreg
      $error("mc_core: NREG must be a power of two in 2..32");
   end

   step_e             step_q;
   xfer_t             xfer;
   logic [ADDR_W-1:0] pc_q, mar_q;
   logic [ILEN-1:0]   ir_q;
   logic [DATA_W-1:0] mdr_q, a_q, b_q, c_q;
   logic [DATA_W-1:0] xbus, alu_y, rf_rdata;
   logic [5:0]        opc;
   logic [RIDX_W-1:0] rd_f, rs1_f, rs2_f, rf_raddr, rf_waddr;
   logic              rf_we, core_we;
   logic [DATA_W-1:0] rf_wdata;

   assign opc   = ir_q[31:26];
   assign rd_f  = ir_q[21 +: RIDX_W];
   assign rs1_f = ir_q[16 +: RIDX_W];
   assign rs2_f = ir_q[11 +: RIDX_W];

   mc_sequencer u_seq (
      .clk  (clk),
      .rst  (rst),
      .opc  (opc),
      .step (step_q),
      .xfer (xfer)
   );

   mc_alu #(.DATA_W(DATA_W)) u_alu (
      .opc (opc),
      .a   (a_q),
      .b   (b_q),
      .y   (alu_y)
   );

   assign rf_raddr = xfer.rf_sel_b ? rs2_f : rs1_f;
   assign core_we  = (xfer.dst == DST_RF);
   assign rf_we    = core_we || dbg_we;
   assign rf_waddr = core_we ? rd_f : dbg_idx;
   assign rf_wdata = core_we ? xbus : dbg_wdata;

   mc_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
      .clk     (clk),
      .we      (rf_we),
      .waddr   (rf_waddr),
      .wdata   (rf_wdata),
      .raddr_a (rf_raddr),
      .rdata_a (rf_rdata),
      .raddr_d (dbg_idx),
      .rdata_d (dbg_rdata)
   );

   // single transfer bus: one source per step
   always_comb begin
      case (xfer.src)
         SRC_PC:    xbus = DATA_W'(pc_q);
         SRC_PCINC: xbus = DATA_W'(pc_q + ADDR_W'(4));
         SRC_MEM:   xbus = mem_rdata;
         SRC_MDR:   xbus = mdr_q;
         SRC_RF:    xbus = rf_rdata;
         SRC_ALU:   xbus = alu_y;
         SRC_C:     xbus = c_q;
         default:   xbus = '0;
      endcase
   end

   // control registers: cleared by reset
   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q  <= '0;
         mar_q <= '0;
         ir_q  <= '0;
      end else begin
         if (xfer.dst == DST_PC)  pc_q  <= xbus[ADDR_W-1:0];
         if (xfer.dst == DST_MAR) mar_q <= xbus[ADDR_W-1:0];
         if (xfer.dst == DST_IR)  ir_q  <= xbus[ILEN-1:0];
      end
   end

   // data latches: no reset needed, always written before use
   always_ff @(posedge clk) begin
      if (xfer.dst == DST_MDR) mdr_q <= xbus;
      if (xfer.dst == DST_A)   a_q   <= xbus;
      if (xfer.dst == DST_B)   b_q   <= xbus;
      if (xfer.dst == DST_C)   c_q   <= xbus;
   end

   assign mem_addr = mar_q;
   assign mem_rd   = xfer.mem_rd;
   assign halted   = (step_q == ST_STOP);

   logic unused_bits;
   assign unused_bits = ^{ir_q, xbus};

endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32,
   parameter int RIDX_W = 5
) (
   input logic              clk,
   input logic              rst,
   input mc_pkg::step_e     step,
   input logic [ADDR_W-1:0] pc,
   input logic [DATA_W-1:0] mdr,
   input logic [31:0]       ir,
   input logic              mem_rd,
   input logic              halted,
   input logic [RIDX_W-1:0] dbg_idx,
   input logic [DATA_W-1:0] dbg_rdata
);
   import mc_pkg::*;

   a_r1_ir_from_mdr: assert property (@(posedge clk) disable iff (rst)
      (step == ST_F_IR) |=> (ir == $past(mdr[31:0])));

   a_r1_single_strobe: assert property (@(posedge clk) disable iff (rst)
      mem_rd |=> !mem_rd);

   a_r2_pc_plus4: assert property (@(posedge clk) disable iff (rst)
      (step == ST_F_PC) |=> (pc == $past(pc) + ADDR_W'(4)));

   a_r3_pc_held_in_exec: assert property (@(posedge clk) disable iff (rst)
      (step == ST_X_B) |=> $stable(pc));

   a_r5_zero_reg: assert property (@(posedge clk) disable iff (rst)
      (dbg_idx == '0) |-> (dbg_rdata == '0));

   a_r7_stop_sticky: assert property (@(posedge clk) disable iff (rst)
      halted |=> halted);

   a_r7_no_read_stopped: assert property (@(posedge clk) disable iff (rst)
      halted |-> !mem_rd);

endmodule

bind mc_core mc_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RIDX_W(RIDX_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .step      (step_q),
   .pc        (pc_q),
   .mdr       (mdr_q),
   .ir        (ir_q),
   .mem_rd    (mem_rd),
   .halted    (halted),
   .dbg_idx   (dbg_idx),
   .dbg_rdata (dbg_rdata)
);

// File: tb/sim_mc_core.sv
module sim_mc_core;

   localparam int NI = 36;   // instructions before the stop

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] mem_addr;
   logic        mem_rd;
   logic [31:0] mem_rdata;
   logic [4:0]  dbg_idx = '0;
   logic        dbg_we = 1'b0;
   logic [31:0] dbg_wdata = '0;
   logic [31:0] dbg_rdata;
   logic        halted;

   always #2 clk = ~clk;

   mc_core u0 (
      .clk (clk), .rst (rst),
      .mem_addr (mem_addr), .mem_rd (mem_rd), .mem_rdata (mem_rdata),
      .dbg_idx (dbg_idx), .dbg_we (dbg_we), .dbg_wdata (dbg_wdata),
      .dbg_rdata (dbg_rdata), .halted (halted)
   );

   logic [31:0] mem [64];
   always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[7:2]];

   int n_cmp = 0;
   int n_bad = 0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // fetch monitor, sampled on the falling edge
   int          cyc = 0, nrd = 0, halt_cyc = -1;
   logic [31:0] rd_addr [64];
   int          rd_cyc  [64];
   always @(negedge clk) begin
      if (rst) begin
         cyc = 0; nrd = 0; halt_cyc = -1;
      end else begin
         if (mem_rd && nrd < 64) begin
            rd_addr[nrd] = mem_addr;
            rd_cyc[nrd]  = cyc;
            nrd++;
         end
         if (halted && halt_cyc < 0) halt_cyc = cyc;
         cyc++;
      end
   end

   function automatic logic [31:0] enc(input logic [5:0] op, input int rd, input int s1, input int s2);
      return {op, 5'(rd), 5'(s1), 5'(s2), 11'b0};
   endfunction

   function automatic logic [31:0] seed(input int k);
      return 32'(k) * 32'h9E37_79B1 + 32'h0000_1234;
   endfunction

   logic [5:0]  ops [NI];
   int          f_rd [NI], f_s1 [NI], f_s2 [NI];
   logic [31:0] model [32];

   task automatic summary;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #(4 * 150000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      // program: sweep of ops and register triples
      for (int i = 0; i < 64; i++) mem[i] = 32'h0;
      for (int i = 0; i < NI; i++) begin
         ops[i]  = (i == 10) ? 6'd9 : (i == 27) ? 6'd63 : 6'((i % 4) + 1);
         f_rd[i] = (i == 20) ? 0 : (i * 7 + 3) % 32;
         f_s1[i] = (i * 5 + 1) % 32;
         f_s2[i] = (i == 33) ? f_rd[i] : (i * 11 + 2) % 32;
         mem[i]  = enc(ops[i], f_rd[i], f_s1[i], f_s2[i]);
      end
      mem[NI] = enc(6'd0, 5, 1, 2);   // stop with nonzero fields

      // software model
      for (int k = 0; k < 32; k++) model[k] = (k == 0) ? 32'h0 : seed(k);
      for (int i = 0; i < NI; i++) begin
         logic [31:0] x, y, r;
         x = model[f_s1[i]]; y = model[f_s2[i]];
         case (ops[i])
            6'd1: r = x + y;
            6'd2: r = x - y;
            6'd3: r = x & y;
            6'd4: r = x | y;
            default: r = 32'h0;
         endcase
         if (ops[i] >= 6'd1 && ops[i] <= 6'd4 && f_rd[i] != 0) model[f_rd[i]] = r;
      end

      // reset phase: seed registers through the debug port (R9)
      @(negedge clk);
      check("R8 mem_rd low in reset", {31'b0, mem_rd}, 32'h0);
      check("R8 halted low in reset", {31'b0, halted}, 32'h0);
      for (int k = 0; k < 32; k++) begin
         @(posedge clk); #1;
         dbg_idx = 5'(k); dbg_we = 1'b1; dbg_wdata = seed(k);
      end
      @(posedge clk); #1;
      dbg_we = 1'b0; dbg_idx = 5'd0;
      @(negedge clk);
      check("R5 r0 ignores debug write", dbg_rdata, 32'h0);
      dbg_idx = 5'd17;
      @(negedge clk);
      check("R9 debug seed readback", dbg_rdata, seed(17));

      @(posedge clk); #1;
      rst = 1'b0;

      for (int w = 0; w < 3000 && !halted; w++) @(negedge clk);
      repeat (10) @(negedge clk);

      check("R7 halted after stop", {31'b0, halted}, 32'h1);
      check("R7 no reads after stop", 32'(nrd), 32'(NI + 1));
      if (nrd >= 1) check("R1 first strobe cycle", 32'(rd_cyc[0]), 32'd1);
      for (int i = 0; i <= NI && i < nrd; i++)
         check("R2 fetch address", rd_addr[i], 32'(4 * i));
      for (int i = 0; i < NI && i + 1 < nrd; i++) begin
         if (ops[i] >= 6'd1 && ops[i] <= 6'd4)
            check("R3 ALU instruction spacing", 32'(rd_cyc[i+1] - rd_cyc[i]), 32'd9);
         else
            check("R6 undefined opcode spacing", 32'(rd_cyc[i+1] - rd_cyc[i]), 32'd6);
      end
      if (nrd == NI + 1) check("R7 halt timing", 32'(halt_cyc), 32'(rd_cyc[NI] + 5));

      // register contents against the model (R3 R4 R5 R6)
      for (int k = 0; k < 32; k++) begin
         @(posedge clk); #1;
         dbg_idx = 5'(k);
         @(negedge clk);
         check($sformatf("R4 reg %0d", k), dbg_rdata, model[k]);
      end

      // debug write while stopped (R9), and into r0 (R5)
      @(posedge clk); #1;
      dbg_idx = 5'd7; dbg_we = 1'b1; dbg_wdata = 32'hA5A5_0F0F;
      @(posedge clk); #1;
      dbg_we = 1'b0;
      @(negedge clk);
      check("R9 debug write while stopped", dbg_rdata, 32'hA5A5_0F0F);
      @(posedge clk); #1;
      dbg_idx = 5'd0; dbg_we = 1'b1; dbg_wdata = 32'hFFFF_FFFF;
      @(posedge clk); #1;
      dbg_we = 1'b0;
      @(negedge clk);
      check("R5 r0 stays zero", dbg_rdata, 32'h0);

      // second reset restarts from address 0 (R8)
      @(posedge clk); #1;
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check("R8 halted cleared by reset", {31'b0, halted}, 32'h0);
      @(posedge clk); #1;
      rst = 1'b0;
      repeat (4) @(negedge clk);
      check("R8 refetch count", 32'(nrd), 32'd1);
      if (nrd >= 1) check("R8 refetch address", rd_addr[0], 32'h0);

      summary();
      $finish;
   end

endmodule